// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the hardware part of taking an interrupt on a 16-bit processor that uses segmented addressing. It waits for a pending request to meet an instruction boundary. It then saves three context words on a downward-growing stack and fetches a new instruction pointer and code segment from a vector table. Finally it hands the updated registers back to the core with the interrupt-enable and trap flags cleared.

The core supplies its current FLAGS, CS, IP, SS and SP values as inputs, and the block samples them at the moment it accepts the request. All five memory accesses use one word-wide port with a request/acknowledge handshake, so any number of wait cycles is tolerated. When the last read completes, the block raises a single-cycle `done` strobe. The replacement FLAGS, CS, IP and SP values are valid on their outputs in that same cycle, and the core loads them then. SS is only read and is never changed.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a cycle where the block is idle and both `irq_req` and `insn_done` are high. `busy` goes high on the following cycle. A request without `insn_done`, or `insn_done` without a request, starts nothing.
- R2: The first memory access is a write (`mem_we`=1) of the sampled FLAGS value, taken before any bit is cleared, to physical address SS×16 + (SP−2).
- R3: The second access writes the sampled CS to SS×16 + (SP−4). The third writes the sampled IP to SS×16 + (SP−6). The physical address is 20 bits wide and wraps modulo 2^20.
- R4: Stack-pointer arithmetic wraps modulo 2^16. With SP = 0x0001, the three pushes go to offsets 0xFFFF, 0xFFFD and 0xFFFB, and the new SP is 0xFFFB.
- R5: The fourth access is a read (`mem_we`=0) at byte address type×4, and its data becomes the new IP. The fifth is a read at type×4+2, and its data becomes the new CS. Vector reads never address above 0x003FF.
- R6: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values and `mem_req` stays high. Each access completes only in a cycle with `mem_ack` high.
- R7: Exactly one cycle after the fifth acknowledge, `done` is high for exactly one cycle. In that cycle `new_ip` and `new_cs` carry the two vector words, `new_sp` equals SP−6, and `new_flags` equals the sampled FLAGS with bit 9 (interrupt enable) and bit 8 (trap) forced to 0.
- R8: A request raised while `busy` is high, including during the `done` cycle, is ignored. The sequence still makes exactly five accesses and uses the type code it accepted.
- R9: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Pending interrupt request |
| irq_type | input | 8 | Interrupt type code, sampled on acceptance |
| insn_done | input | 1 | High in a cycle where the current instruction retires |
| flags_in | input | 16 | Current FLAGS register |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete in this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe; load new values now |
| new_flags | output | 16 | FLAGS to load at `done` |
| new_cs | output | 16 | CS to load at `done` |
| new_ip | output | 16 | IP to load at `done` |
| new_sp | output | 16 | SP to load at `done` |

## Verification
The hardest case to provoke is a second request that lands in the middle of a running sequence with a different type code. If the block took it, the damage would only show later, as a sixth access or as a vector fetched from the wrong slot. The bench raises `irq_req` together with `insn_done` and a changed type two cycles into the push phase, while the memory model is inserting wait states. It then checks that exactly five accesses occur and that both vector addresses come from the first type. Wait states that vary from table entry to entry keep the port held across several cycles, so the stability rule is checked on stalled accesses.

// File: rtl/ies_pkg.sv
package ies_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PUSH_FL = 3'd1,
      ST_PUSH_CS = 3'd2,
      ST_PUSH_IP = 3'd3,
      ST_VEC_IP  = 3'd4,
      ST_VEC_CS  = 3'd5,
      ST_FIN     = 3'd6
   } ies_step_e;

   function automatic logic step_is_push(ies_step_e s);
      return (s == ST_PUSH_FL) || (s == ST_PUSH_CS) || (s == ST_PUSH_IP);
   endfunction

   function automatic logic step_is_vec(ies_step_e s);
      return (s == ST_VEC_IP) || (s == ST_VEC_CS);
   endfunction

endpackage

// File: rtl/ies_phys_addr.sv
module ies_phys_addr #(
   parameter int OFS_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = OFS_W + SEG_SHIFT
) (
   input  logic [OFS_W-1:0]  seg,
   input  logic [OFS_W-1:0]  ofs,
   output logic [ADDR_W-1:0] phys
);
   if (ADDR_W < OFS_W) begin : g_bad_w
      $error("ies_phys_addr: ADDR_W must be at least OFS_W");
   end

   if (SEG_SHIFT == 0) begin : g_flat
      assign phys = ADDR_W'(seg) + ADDR_W'(ofs);
   end else begin : g_shifted
      logic [OFS_W+SEG_SHIFT-1:0] seg_base;
      assign seg_base = {seg, {SEG_SHIFT{1'b0}}};
      assign phys     = ADDR_W'(seg_base) + ADDR_W'(ofs);
   end
endmodule

// File: rtl/ies_flag_mask.sv
module ies_flag_mask #(
   parameter int W        = 16,
   parameter int IE_POS   = 9,
   parameter int TRAP_POS = 8
) (
   input  logic [W-1:0] flags_raw,
   output logic [W-1:0] flags_masked
);
   if (IE_POS >= W || TRAP_POS >= W || IE_POS == TRAP_POS) begin : g_bad_pos
      $error("ies_flag_mask: flag positions out of range or equal");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == IE_POS || i == TRAP_POS) begin : g_clr
         assign flags_masked[i] = 1'b0;
      end else begin : g_keep
         assign flags_masked[i] = flags_raw[i];
      end
   end
endmodule

// File: rtl/ies_step_ctrl.sv
module ies_step_ctrl
   import ies_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      ack,
   output ies_step_e step,
   output logic      accept,
   output logic      advance
);
   ies_step_e step_q, step_d;

   assign accept  = (step_q == ST_IDLE) && start;
   assign advance = (step_is_push(step_q) || step_is_vec(step_q)) && ack;

   always_comb begin
      step_d = step_q;
      unique case (step_q)
         ST_IDLE:    if (start)   step_d = ST_PUSH_FL;
         ST_PUSH_FL: if (advance) step_d = ST_PUSH_CS;
         ST_PUSH_CS: if (advance) step_d = ST_PUSH_IP;
         ST_PUSH_IP: if (advance) step_d = ST_VEC_IP;
         ST_VEC_IP:  if (advance) step_d = ST_VEC_CS;
         ST_VEC_CS:  if (advance) step_d = ST_FIN;
         ST_FIN:                  step_d = ST_IDLE;
         default:                 step_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= ST_IDLE;
      else        step_q <= step_d;
   end

   assign step = step_q;

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_IDLE && !start) |=> (step_q == ST_IDLE));

   // R6
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q != ST_IDLE && step_q != ST_FIN && !ack) |=> $stable(step_q));

   // R7
   fin_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_FIN) |=> (step_q == ST_IDLE));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import ies_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int TYPE_W    = 8,
   parameter int SEG_SHIFT = 4,
   parameter int IE_POS    = 9,
   parameter int TRAP_POS  = 8,
   localparam int ADDR_W   = DATA_W + SEG_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [TYPE_W-1:0] irq_type,
   input  logic              insn_done,
   input  logic [DATA_W-1:0] flags_in,
   input  logic [DATA_W-1:0] cs_in,
   input  logic [DATA_W-1:0] ip_in,
   input  logic [DATA_W-1:0] ss_in,
   input  logic [DATA_W-1:0] sp_in,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] new_flags,
   output logic [DATA_W-1:0] new_cs,
   output logic [DATA_W-1:0] new_ip,
   output logic [DATA_W-1:0] new_sp
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int VEC_SHIFT  = $clog2(2 * WORD_BYTES);
   localparam int VEC_TOP    = TYPE_W + VEC_SHIFT;

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
      $error("irq_entry_seq: DATA_W must be a multiple of 8, at least 16");
   end
   if (VEC_TOP > DATA_W) begin : g_bad_type
      $error("irq_entry_seq: vector table does not fit one offset word");
   end

   ies_step_e         step;
   logic              accept, advance;
   logic [TYPE_W-1:0] type_q;
   logic [DATA_W-1:0] flags_q, cs_q, ip_q, ss_q, sp_q;
   logic [DATA_W-1:0] vec_ip_q, vec_cs_q;
   logic [DATA_W-1:0] seg_sel, ofs_sel, vec_ofs;
   logic [DATA_W-1:0] flags_clr;

   ies_step_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (irq_req && insn_done),
      .ack     (mem_ack),
      .step    (step),
      .accept  (accept),
      .advance (advance)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q  <= '0;
         flags_q <= '0;
         cs_q    <= '0;
         ip_q    <= '0;
         ss_q    <= '0;
         sp_q    <= '0;
      end else if (accept) begin
         type_q  <= irq_type;
         flags_q <= flags_in;
         cs_q    <= cs_in;
         ip_q    <= ip_in;
         ss_q    <= ss_in;
         sp_q    <= sp_in - DATA_W'(WORD_BYTES);
      end else if (advance && (step == ST_PUSH_FL || step == ST_PUSH_CS)) begin
         sp_q    <= sp_q - DATA_W'(WORD_BYTES);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_ip_q <= '0;
         vec_cs_q <= '0;
      end else if (advance) begin
         if (step == ST_VEC_IP) vec_ip_q <= mem_rdata;
         if (step == ST_VEC_CS) vec_cs_q <= mem_rdata;
      end
   end

   assign vec_ofs = DATA_W'({type_q, {VEC_SHIFT{1'b0}}})
                  + ((step == ST_VEC_CS) ? DATA_W'(WORD_BYTES) : '0);

   always_comb begin
      if (step_is_vec(step)) begin
         seg_sel = '0;
         ofs_sel = vec_ofs;
      end else begin
         seg_sel = ss_q;
         ofs_sel = sp_q;
      end
   end

   ies_phys_addr #(
      .OFS_W     (DATA_W),
      .SEG_SHIFT (SEG_SHIFT),
      .ADDR_W    (ADDR_W)
   ) u_addr (
      .seg  (seg_sel),
      .ofs  (ofs_sel),
      .phys (mem_addr)
   );

   always_comb begin
      unique case (step)
         ST_PUSH_FL: mem_wdata = flags_q;
         ST_PUSH_CS: mem_wdata = cs_q;
         ST_PUSH_IP: mem_wdata = ip_q;
         default:    mem_wdata = '0;
      endcase
   end

   ies_flag_mask #(
      .W        (DATA_W),
      .IE_POS   (IE_POS),
      .TRAP_POS (TRAP_POS)
   ) u_mask (
      .flags_raw    (flags_q),
      .flags_masked (flags_clr)
   );

   assign mem_req   = step_is_push(step) || step_is_vec(step);
   assign mem_we    = step_is_push(step);
   assign busy      = (step != ST_IDLE);
   assign done      = (step == ST_FIN);
   assign new_flags = flags_clr;
   assign new_cs    = vec_cs_q;
   assign new_ip    = vec_ip_q;
   assign new_sp    = sp_q;

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!mem_req && !busy && !done));

   // R6
   port_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                 && $stable(mem_we) && $stable(mem_wdata)));

   // R8
   type_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(type_q) && $stable(flags_q)));

   // R5
   vec_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr >> VEC_TOP) == '0);

   // R7
   flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!new_flags[IE_POS] && !new_flags[TRAP_POS]));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ack && mem_we && step != ST_PUSH_IP && busy)
         |=> (sp_q == $past(sp_q) - DATA_W'(WORD_BYTES)));
endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [7:0]  irq_type = '0;
   logic        insn_done = 1'b0;
   logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
   logic        mem_req, mem_we;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        busy, done;
   logic [15:0] new_flags, new_cs, new_ip, new_sp;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   irq_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_type(irq_type),
      .insn_done(insn_done), .flags_in(flags_in), .cs_in(cs_in),
      .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
      .new_flags(new_flags), .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp)
   );

   always #5 clk = ~clk;

   typedef struct packed {
      logic [7:0]  typ;
      logic [15:0] fl, cs, ip, ss, sp;
      logic [3:0]  wt;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{8'h08, 16'hF3D7, 16'h1234, 16'h5678, 16'h2000, 16'hFFFE, 4'd0},
      '{8'hFF, 16'h0000, 16'hFFFF, 16'h0001, 16'hFFFF, 16'h0010, 4'd2},
      '{8'h00, 16'h0300, 16'hA5A5, 16'h5A5A, 16'h0000, 16'h0001, 4'd1},
      '{8'h80, 16'hFCFF, 16'h0F0F, 16'hF0F0, 16'h1000, 16'h0004, 4'd3},
      '{8'h13, 16'h0200, 16'h7777, 16'h8888, 16'h0ABC, 16'h0006, 4'd0}
   };

   function automatic logic [15:0] mem_fn(logic [19:0] a);
      return ~a[15:0] ^ {a[19:16], 12'h5A3};
   endfunction

   function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
      return {s, 4'h0} + {4'h0, o};
   endfunction

   // memory model with programmable wait states, logs each completed access
   logic [3:0]  wait_cfg = '0;
   int          wcnt = 0;
   int          nacc = 0;
   int          ndone = 0;
   logic [19:0] log_addr [64];
   logic        log_we   [64];
   logic [15:0] log_data [64];
   logic        pend = 1'b0;
   logic [19:0] p_addr;
   logic        p_we;
   logic [15:0] p_data;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && mem_req) begin
         if (pend)
            check(mem_addr == p_addr && mem_we == p_we && mem_wdata == p_data,
                  "R6", "port changed while stalled", {12'h0, mem_addr},
                  {12'h0, p_addr});
         if (wcnt == int'(wait_cfg)) begin
            mem_ack = 1'b1;
            mem_rdata = mem_fn(mem_addr);
            log_addr[nacc % 64] = mem_addr;
            log_we[nacc % 64]   = mem_we;
            log_data[nacc % 64] = mem_wdata;
            nacc++;
            wcnt = 0;
            pend = 1'b0;
         end else begin
            mem_ack = 1'b0;
            wcnt++;
            pend = 1'b1;
            p_addr = mem_addr;
            p_we = mem_we;
            p_data = mem_wdata;
         end
      end else begin
         mem_ack = 1'b0;
         wcnt = 0;
         pend = 1'b0;
      end
      if (rst_n && done) ndone++;
   end

   task automatic run_seq(input vec_t v, input bit inject);
      int base_a, base_d, cyc;
      bit seen;
      logic [15:0] got_fl, got_cs, got_ip, got_sp;
      logic [15:0] sp2, sp4, sp6;
      logic [19:0] vb;
      @(negedge clk);
      irq_type = v.typ; flags_in = v.fl; cs_in = v.cs; ip_in = v.ip;
      ss_in = v.ss; sp_in = v.sp; wait_cfg = v.wt;
      base_a = nacc; base_d = ndone;
      irq_req = 1'b1; insn_done = 1'b1;
      @(negedge clk);
      irq_req = 1'b0; insn_done = 1'b0;
      check(busy == 1'b1, "R1", "busy after accept", {31'h0, busy}, 32'h1);
      cyc = 0; seen = 0;
      got_fl = '0; got_cs = '0; got_ip = '0; got_sp = '0;
      while (!seen && cyc < 200) begin
         if (inject && cyc == 2) begin
            irq_req = 1'b1; insn_done = 1'b1; irq_type = v.typ ^ 8'h5A;
         end else if (inject && cyc == 4) begin
            irq_req = 1'b0; insn_done = 1'b0;
         end
         @(negedge clk);
         cyc++;
         if (done) begin
            seen = 1;
            got_fl = new_flags; got_cs = new_cs; got_ip = new_ip; got_sp = new_sp;
         end
      end
      irq_req = 1'b0; insn_done = 1'b0;
      repeat (3) @(negedge clk);
      sp2 = v.sp - 16'd2; sp4 = v.sp - 16'd4; sp6 = v.sp - 16'd6;
      vb  = {10'h0, v.typ, 2'b00};
      check(seen, "R7", "done seen", {31'h0, seen}, 32'h1);
      check(nacc - base_a == 5, "R8", "access count", nacc - base_a, 5);
      check(ndone - base_d == 1, "R7", "done pulse count", ndone - base_d, 1);
      check(log_we[base_a % 64] && log_addr[base_a % 64] == phys(v.ss, sp2)
            && log_data[base_a % 64] == v.fl, "R2", "flags push",
            {12'h0, log_addr[base_a % 64]}, {12'h0, phys(v.ss, sp2)});
      check(log_we[(base_a+1) % 64] && log_addr[(base_a+1) % 64] == phys(v.ss, sp4)
            && log_data[(base_a+1) % 64] == v.cs, "R3", "cs push",
            {12'h0, log_addr[(base_a+1) % 64]}, {12'h0, phys(v.ss, sp4)});
      check(log_we[(base_a+2) % 64] && log_addr[(base_a+2) % 64] == phys(v.ss, sp6)
            && log_data[(base_a+2) % 64] == v.ip, "R3", "ip push",
            {12'h0, log_addr[(base_a+2) % 64]}, {12'h0, phys(v.ss, sp6)});
      check(!log_we[(base_a+3) % 64] && log_addr[(base_a+3) % 64] == vb,
            "R5", "ip vector read", {12'h0, log_addr[(base_a+3) % 64]}, {12'h0, vb});
      check(!log_we[(base_a+4) % 64] && log_addr[(base_a+4) % 64] == vb + 20'd2,
            "R5", "cs vector read", {12'h0, log_addr[(base_a+4) % 64]},
            {12'h0, vb + 20'd2});
      check(got_ip == mem_fn(vb), "R5", "new ip", {16'h0, got_ip}, {16'h0, mem_fn(vb)});
      check(got_cs == mem_fn(vb + 20'd2), "R5", "new cs", {16'h0, got_cs},
            {16'h0, mem_fn(vb + 20'd2)});
      check(got_sp == sp6, "R4", "new sp", {16'h0, got_sp}, {16'h0, sp6});
      check(got_fl == (v.fl & 16'hFCFF), "R7", "new flags", {16'h0, got_fl},
            {16'h0, v.fl & 16'hFCFF});
      check(!busy, "R7", "idle after done", {31'h0, busy}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !mem_req, "R9", "reset outputs",
            {29'h0, busy, done, mem_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !mem_req, "R9", "after reset release",
            {30'h0, busy, mem_req}, 32'h0);

      foreach (VECS[i]) run_seq(VECS[i], 1'b0);

      // R1: request without boundary, boundary without request
      irq_req = 1'b1; insn_done = 1'b0;
      repeat (5) @(negedge clk);
      check(!busy && !mem_req, "R1", "request without boundary",
            {30'h0, busy, mem_req}, 32'h0);
      irq_req = 1'b0; insn_done = 1'b1;
      repeat (5) @(negedge clk);
      check(!busy && !mem_req, "R1", "boundary without request",
            {30'h0, busy, mem_req}, 32'h0);
      insn_done = 1'b0;

      // R8: second request mid-sequence with another type
      run_seq(VECS[1], 1'b1);
      run_seq(VECS[2], 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule